// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power modes of a small 8-bit microcontroller core. It holds a two-bit power control register that the core writes, and it drives three clock enables: one for the CPU, one for the peripherals and one for the internal oscillator. It also drives an enable for the missing-clock detector, which stays on in every mode.

Setting the idle bit arms idle mode. Idle takes effect only when the core reports that the current instruction has finished. In idle, only the CPU clock stops. Any interrupt that is both enabled and pending returns the core to run mode. It clears the idle bit, restarts the CPU clock and pulses a wake indication for one cycle.

Setting the stop bit halts the CPU, the peripherals and the oscillator, and interrupts are ignored. Only a watchdog reset or an external reset strobe ends stop mode. Either strobe returns every mode to run and pulses a restart request, which makes the core fetch again from address zero.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n_i`, and two clock cycles after its release, the CPU, peripheral, oscillator and detector enables are 1. The wake and restart outputs are 0, and the register reads 0x00.
- R2: A write with bit 0 = 1 and bit 1 = 0 sets the idle bit (read bit 0) in the next cycle. Register bits 7:2 always read 0. Writing a bit as 0 leaves it unchanged. The CPU clock stays enabled until an instruction-complete strobe.
- R3: Idle is entered in the cycle after the first instruction-complete strobe seen while the idle bit is set, or seen in the cycle of the write itself. In idle the CPU enable is 0, and the peripheral and oscillator enables stay 1.
- R4: In idle, an interrupt line with both `irq_pend_i[k]` and `irq_en_i[k]` at 1 returns the block to run in the next cycle. That cycle has CPU enable 1, idle bit 0 and `wake_o` = 1, and `wake_o` falls again in the cycle after.
- R5: In idle, interrupt lines that are pending but not enabled, or enabled but not pending, do not wake the core.
- R6: An enabled, pending interrupt that arrives while idle is armed but not yet entered clears the idle bit. A later instruction-complete strobe then does not enter idle, and `wake_o` stays 0.
- R7: A write with bit 1 = 1 sets the stop bit. On the next instruction-complete strobe (or one in the same cycle), the CPU, peripheral and oscillator enables all go to 0 in the following cycle.
- R8: In stop mode, interrupts have no effect: the enables stay 0 and the register keeps reading 0x02.
- R9: When bits 0 and 1 are both written as 1 in one write, stop wins. The register reads 0x02 and the block enters stop, not idle.
- R10: A watchdog or external reset strobe, in any mode, returns the block to run in the next cycle. Both bits clear and `restart_o` pulses for exactly one cycle. The strobe overrides a write or an interrupt in the same cycle, and `wake_o` stays 0.
- R11: The missing-clock-detector enable `mcd_en_o` is 1 in run, idle and stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| pcon_wr_i | input | 1 | Power control register write strobe |
| pcon_wdata_i | input | 8 | Write data: bit 0 idle, bit 1 stop |
| pcon_rdata_o | output | 8 | Read-back of the power control register |
| instr_done_i | input | 1 | Current instruction has finished executing |
| irq_pend_i | input | N_IRQ | Interrupt pending lines |
| irq_en_i | input | N_IRQ | Interrupt enable lines |
| wdt_rst_i | input | 1 | Watchdog reset strobe |
| ext_rst_i | input | 1 | External reset strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Internal oscillator enable |
| mcd_en_o | output | 1 | Missing-clock detector enable |
| wake_o | output | 1 | One-cycle pulse on leaving idle by interrupt |
| restart_o | output | 1 | One-cycle pulse asking the core to restart at address zero |

## Verification
Three pairs of functions can fall in the same cycle: an idle request and the instruction-complete strobe, an enabled interrupt and a reset strobe, and a register write and a reset strobe. The vector table drives each pair together in a single cycle. After the next edge it compares the enables, the two pulses and the read-back against the winner that the requirements name. A further vector sends an interrupt during the window between arming idle and the end of the instruction, and the check confirms that idle is never entered.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned PCON_W   = 8;
  localparam int unsigned IDLE_POS = 0;
  localparam int unsigned STOP_POS = 1;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pmc_irq_detect.sv
module pmc_irq_detect #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] en_i,
  output logic             hit_o
);
  logic [N_IRQ-1:0] live;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_line
      assign live[g] = pend_i[g] & en_i[g];
    end
  endgenerate

  assign hit_o = |live;
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_i,
  input  logic [PCON_W-1:0] wdata_i,
  input  logic              irq_hit_i,
  input  logic              rst_strobe_i,
  output logic              idle_q_o,
  output logic              stop_q_o,
  output logic              idle_nxt_o,
  output logic              stop_nxt_o,
  output logic [PCON_W-1:0] rdata_o
);
  logic idle_q, stop_q;
  logic idle_d, stop_d;
  logic set_stop, set_idle;

  assign set_stop = wr_i & wdata_i[STOP_POS];
  assign set_idle = wr_i & wdata_i[IDLE_POS] & ~wdata_i[STOP_POS];

  always_comb begin
    idle_d = idle_q;
    stop_d = stop_q;
    if (rst_strobe_i) begin
      idle_d = 1'b0;
      stop_d = 1'b0;
    end else begin
      if (set_stop) begin
        stop_d = 1'b1;
        idle_d = 1'b0;
      end else if (set_idle && !stop_q) begin
        idle_d = 1'b1;
      end
      if (irq_hit_i && !stop_q) begin
        idle_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      idle_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      stop_q <= stop_d;
    end
  end

  assign idle_q_o   = idle_q;
  assign stop_q_o   = stop_q;
  assign idle_nxt_o = idle_d;
  assign stop_nxt_o = stop_d;

  always_comb begin
    rdata_o           = '0;
    rdata_o[IDLE_POS] = idle_q;
    rdata_o[STOP_POS] = stop_q;
  end

  // R6
  irq_clears_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (irq_hit_i && !stop_q) |=> !idle_q);

  // R9
  stop_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && wdata_i[STOP_POS] && !rst_strobe_i) |=> (stop_q && !idle_q));

  // R10
  strobe_clears_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_strobe_i |=> (!idle_q && !stop_q));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic instr_done_i,
  input  logic idle_nxt_i,
  input  logic stop_nxt_i,
  input  logic irq_hit_i,
  input  logic rst_strobe_i,
  output logic cpu_en_o,
  output logic periph_en_o,
  output logic osc_en_o,
  output logic wake_o,
  output logic restart_o
);
  pm_state_e state_q, state_d;
  logic      wake_q, wake_d;
  logic      restart_q, restart_d;

  always_comb begin
    state_d   = state_q;
    wake_d    = 1'b0;
    restart_d = rst_strobe_i;
    if (rst_strobe_i) begin
      state_d = PM_RUN;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (instr_done_i && stop_nxt_i)      state_d = PM_STOP;
          else if (instr_done_i && idle_nxt_i) state_d = PM_IDLE;
        end
        PM_IDLE: begin
          if (irq_hit_i) begin
            state_d = PM_RUN;
            wake_d  = 1'b1;
          end
        end
        PM_STOP: state_d = PM_STOP;
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= PM_RUN;
      wake_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wake_q    <= wake_d;
      restart_q <= restart_d;
    end
  end

  assign cpu_en_o    = (state_q == PM_RUN);
  assign periph_en_o = (state_q != PM_STOP);
  assign osc_en_o    = (state_q != PM_STOP);
  assign wake_o      = wake_q;
  assign restart_o   = restart_q;

  // R4
  idle_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == PM_IDLE && irq_hit_i) |=> (state_q == PM_RUN));

  // R4
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wake_q |=> !wake_q);

  // R8
  stop_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == PM_STOP && !rst_strobe_i) |=> (state_q == PM_STOP));

  // R7
  stop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == PM_RUN && instr_done_i && stop_nxt_i && !rst_strobe_i)
      |=> (state_q == PM_STOP));

  // R10
  strobe_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_strobe_i |=> (state_q == PM_RUN && restart_q && !wake_q));

  // R3
  no_early_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == PM_RUN && !instr_done_i) |=> (state_q == PM_RUN));
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned N_IRQ = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              pcon_wr_i,
  input  logic [PCON_W-1:0] pcon_wdata_i,
  output logic [PCON_W-1:0] pcon_rdata_o,
  input  logic              instr_done_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic              wdt_rst_i,
  input  logic              ext_rst_i,
  output logic              cpu_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              osc_en_o,
  output logic              mcd_en_o,
  output logic              wake_o,
  output logic              restart_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       irq_hit;
  logic       rst_strobe;
  logic       idle_q, stop_q, idle_nxt, stop_nxt;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign rst_strobe = wdt_rst_i | ext_rst_i;

  pmc_irq_detect #(.N_IRQ(N_IRQ)) u_irq (
    .pend_i (irq_pend_i),
    .en_i   (irq_en_i),
    .hit_o  (irq_hit)
  );

  pmc_ctrl_reg u_reg (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .wr_i         (pcon_wr_i),
    .wdata_i      (pcon_wdata_i),
    .irq_hit_i    (irq_hit),
    .rst_strobe_i (rst_strobe),
    .idle_q_o     (idle_q),
    .stop_q_o     (stop_q),
    .idle_nxt_o   (idle_nxt),
    .stop_nxt_o   (stop_nxt),
    .rdata_o      (pcon_rdata_o)
  );

  pmc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .instr_done_i (instr_done_i),
    .idle_nxt_i   (idle_nxt),
    .stop_nxt_i   (stop_nxt),
    .irq_hit_i    (irq_hit),
    .rst_strobe_i (rst_strobe),
    .cpu_en_o     (cpu_clk_en_o),
    .periph_en_o  (periph_clk_en_o),
    .osc_en_o     (osc_en_o),
    .wake_o       (wake_o),
    .restart_o    (restart_o)
  );

  assign mcd_en_o = 1'b1;

  // R3
  idle_keeps_periph_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (idle_q && !cpu_clk_en_o) |-> (periph_clk_en_o && osc_en_o));

  // R7
  stop_gates_all_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!osc_en_o) |-> (stop_q && !cpu_clk_en_o && !periph_clk_en_o));
endmodule

// File: tb/pmc_power_ctrl_tb_top.sv
module pmc_power_ctrl_tb_top;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wr, done, wdt, ext;
  logic [7:0] wdata;
  logic [NI-1:0] pend, en;
  logic [7:0] rdata;
  logic cpu, per, osc, mcd, wake, rst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pmc_power_ctrl #(.N_IRQ(NI)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .pcon_wr_i(wr), .pcon_wdata_i(wdata),
    .pcon_rdata_o(rdata), .instr_done_i(done), .irq_pend_i(pend),
    .irq_en_i(en), .wdt_rst_i(wdt), .ext_rst_i(ext),
    .cpu_clk_en_o(cpu), .periph_clk_en_o(per), .osc_en_o(osc),
    .mcd_en_o(mcd), .wake_o(wake), .restart_o(rst_o)
  );

  // exp = {cpu, periph, osc, wake, restart, rd1(stop), rd0(idle)}
  typedef struct packed {
    logic       wr;
    logic [1:0] wd;
    logic       done;
    logic [3:0] pend;
    logic [3:0] en;
    logic       wdt;
    logic       ext;
    logic [6:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'b01,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110001,4'd2},  // R2 arm idle
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110001,4'd2},  // R2 cpu still on
    '{1'b0,2'b00,1'b1,4'h0,4'h0,1'b0,1'b0,7'b0110001,4'd3},  // R3 enter idle
    '{1'b0,2'b00,1'b0,4'h1,4'h0,1'b0,1'b0,7'b0110001,4'd5},  // R5 pending only
    '{1'b0,2'b00,1'b0,4'h0,4'h2,1'b0,1'b0,7'b0110001,4'd5},  // R5 enabled only
    '{1'b0,2'b00,1'b0,4'h4,4'h4,1'b0,1'b0,7'b1111000,4'd4},  // R4 wake
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110000,4'd4},  // R4 pulse ends
    '{1'b1,2'b01,1'b1,4'h0,4'h0,1'b0,1'b0,7'b0110001,4'd3},  // R3 write+done same cycle
    '{1'b0,2'b00,1'b0,4'h8,4'h8,1'b0,1'b0,7'b1111000,4'd4},  // R4 top line wakes
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110000,4'd4},
    '{1'b1,2'b01,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110001,4'd2},
    '{1'b0,2'b00,1'b0,4'h1,4'h1,1'b0,1'b0,7'b1110000,4'd6},  // R6 cancel while armed
    '{1'b0,2'b00,1'b1,4'h0,4'h0,1'b0,1'b0,7'b1110000,4'd6},  // R6 done, no idle
    '{1'b1,2'b11,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110010,4'd9},  // R9 both bits
    '{1'b0,2'b00,1'b1,4'h0,4'h0,1'b0,1'b0,7'b0000010,4'd7},  // R7 enter stop
    '{1'b0,2'b00,1'b0,4'hF,4'hF,1'b0,1'b0,7'b0000010,4'd8},  // R8 irq ignored
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b1,1'b0,7'b1110100,4'd10}, // R10 watchdog
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110000,4'd10}, // R10 pulse ends
    '{1'b1,2'b10,1'b1,4'h0,4'h0,1'b0,1'b0,7'b0000010,4'd7},  // R7 same-cycle stop
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b0,1'b1,7'b1110100,4'd10}, // R10 external
    '{1'b1,2'b01,1'b1,4'h0,4'h0,1'b0,1'b0,7'b0110001,4'd3},
    '{1'b0,2'b00,1'b0,4'h2,4'h2,1'b1,1'b0,7'b1110100,4'd10}, // R10 beats irq
    '{1'b1,2'b01,1'b0,4'h0,4'h0,1'b0,1'b1,7'b1110100,4'd10}, // R10 beats write
    '{1'b1,2'b01,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110001,4'd2},
    '{1'b1,2'b00,1'b0,4'h0,4'h0,1'b0,1'b0,7'b1110001,4'd2},  // R2 zero write no effect
    '{1'b0,2'b00,1'b1,4'h0,4'h0,1'b0,1'b0,7'b0110001,4'd3},
    '{1'b0,2'b00,1'b0,4'h0,4'h0,1'b0,1'b1,7'b1110100,4'd10}
  };

  task automatic idle_in();
    wr = 1'b0; wdata = 8'h00; done = 1'b0; pend = '0; en = '0;
    wdt = 1'b0; ext = 1'b0;
  endtask

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] obs();
    return {mcd, cpu, per, osc, wake, rst_o, rdata[1:0]};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1: watchdog expired actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(1, obs(), 8'b11110000);
    check(1, rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr = VEC[i].wr; wdata = {6'b111111, VEC[i].wd};
      done = VEC[i].done; pend = VEC[i].pend; en = VEC[i].en;
      wdt = VEC[i].wdt; ext = VEC[i].ext;
      @(negedge clk);
      idle_in();
      check(int'(VEC[i].req), obs(), {1'b1, VEC[i].exp});
      check(2, {6'b0, rdata[7:2]} , 8'h00);  // R2 upper bits read 0
      check(11, {7'b0, mcd}, 8'h01);           // R11 detector on
    end

    // R1 asynchronous reset while stopped
    wr = 1'b1; wdata = 8'h02; done = 1'b1;
    @(negedge clk);
    idle_in();
    check(7, obs(), 8'b10000010);
    check(11, {7'b0, mcd}, 8'h01);  // R11 in stop
    #1 rst_n = 1'b0;
    #1;
    check(1, obs(), 8'b11110000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, obs(), 8'b11110000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule